// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Qualifier

This block sits behind the asynchronous control pins of a parallel NOR-style memory. It samples the active-low chip-enable, write-enable and output-enable pins on an internal clock. Each pin passes through a synchronizer and a stable-count filter, so short noise pulses are removed. From the filtered levels it decides when a legal bus write happens. It captures the address when the write opens and the data when it closes. It then emits a one-cycle write strobe that carries both values.

Writes are blocked in three cases: while the supply-good input is low, while output-enable is asserted, and after power-up until the bus has shown write-enable or chip-enable high at least once. A small sequence checker follows the strobes. It expects two fixed unlock pairs and then a command cycle, and it emits a one-cycle command pulse with the command byte. Any write that does not fit the next expected step puts the block back in read-array mode.

A mode flag shows whether reads return array data or status. A read-status output applies the erase-suspend rule: a read that falls inside a suspended sector returns status. The strobes have no ready input and cannot be stalled. A consumer must take each pulse in the cycle it appears.

Top module: `flash_wr_qualifier`

## Requirements
- R1: While `supply_ok` is low (seen three clock edges later), `core_rst` is high, no write strobe or command pulse occurs, and `read_array` is 1.
- R2: A low or high pulse on any of the three bus pins that lasts fewer than GLITCH_CYC clock cycles is ignored. A level held for GLITCH_CYC cycles or longer is accepted.
- R3: A write opens only while the filtered chip-enable and write-enable are both low and output-enable is high. With `oe_n` low, no strobe is produced.
- R4: After reset, a write is refused until `we_n` or `ce_n` has been seen high once. If both are low with `oe_n` high when reset is released, the following rise of `we_n` gives no strobe.
- R5: `wr_addr` is the `bus_addr` value present when the later of the two falling edges (chip-enable or write-enable) is filtered. Later changes of `bus_addr` inside the cycle are not captured.
- R6: `wr_data` is the `bus_data` value present at the earlier of the two rising edges. `wr_valid` is high for exactly one cycle, GLITCH_CYC+3 clock edges after that pin change.
- R7: `read_array` is 1 after reset. A one-cycle `op_done` sets it back to 1 on the next edge.
- R8: The sequence 0x555/0xAA, 0x2AA/0x55, then any address/data gives `cmd_valid` one edge after the third strobe. `cmd_data` equals that data, and `read_array` becomes 0.
- R9: A write that does not match the expected unlock pair sets `read_array` to 1, gives no `cmd_valid`, and restarts the sequence.
- R10: `rd_status` is 1 when `read_array` is 0, or when `susp_en` is 1 and the bit of `susp_mask` selected by `rd_addr[AW-1:AW-3]` (the sector number) is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | High while the supply is above the lockout level |
| ce_n | input | 1 | Bus chip-enable, active low |
| we_n | input | 1 | Bus write-enable, active low |
| oe_n | input | 1 | Bus output-enable, active low |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus write data |
| op_done | input | 1 | Pulse when a program or erase finishes |
| susp_en | input | 1 | Erase-suspend mode is active |
| susp_mask | input | NSECT | One bit per suspended sector |
| rd_addr | input | AW | Address of the current read |
| wr_valid | output | 1 | One-cycle qualified write strobe |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_data | output | DW | Command byte of the accepted sequence |
| read_array | output | 1 | 1 = reads return array data, 0 = status |
| rd_status | output | 1 | Current read returns status |
| core_rst | output | 1 | Reset for downstream program/erase logic |

## Verification
A bus pin change made at a falling clock edge reaches the filtered level after GLITCH_CYC+2 rising edges. The write strobe follows one edge later, and the command pulse one edge after the strobe. `read_array` follows `op_done` on the next edge, and `rd_status` is combinational. The bench drives every input at a falling edge and waits for whole cycles. For the latency test it samples one cycle before the strobe is due, at the cycle it is due, and one cycle after. The other bus cycles hold each pin level for GLITCH_CYC+4 cycles, so every result has settled before it is read.

// File: rtl/flash_wq_pkg.sv
`timescale 1ns/1ps
package flash_wq_pkg;
  typedef enum logic [1:0] {
    SEQ_UNL0 = 2'd0,
    SEQ_UNL1 = 2'd1,
    SEQ_CMD  = 2'd2
  } seq_state_t;

  localparam int PIN_CE = 0;
  localparam int PIN_WE = 1;
  localparam int PIN_OE = 2;
  localparam int NPINS  = 3;
endpackage

// File: rtl/wq_pin_filter.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a stable-count filter.
// The output takes a new level only after the synchronized input has
// held it for GLITCH_CYC consecutive samples. Reset value is 0 (asserted).
module wq_pin_filter #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic flt_n
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
    end
  end

  generate
    if (GLITCH_CYC > 1) begin : g_cnt
      localparam int CW = $clog2(GLITCH_CYC + 1);
      localparam logic [CW-1:0] LIM = CW'(GLITCH_CYC - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt   <= '0;
          flt_n <= 1'b0;
        end else if (s2 == flt_n) begin
          cnt <= '0;
        end else if (cnt == LIM) begin
          cnt   <= '0;
          flt_n <= s2;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_n <= 1'b0;
        else        flt_n <= s2;
      end
    end
  endgenerate
endmodule

// File: rtl/wq_cycle_tracker.sv
`timescale 1ns/1ps
// Opens a write cycle when CE and WE are both low with OE high. This is the
// later of the two falling edges, and the address is captured here. The
// cycle closes at the first rise of CE or WE, where the data is captured.
module wq_cycle_tracker #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          we_f,
  input  logic          oe_f,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic in_cycle;
  logic pu_block;
  logic any_high;

  assign any_high = ce_f | we_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cycle <= 1'b0;
      pu_block <= 1'b1;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (pu_block && any_high) pu_block <= 1'b0;
      if (!in_cycle) begin
        if (!pu_block && !any_high && oe_f) begin
          in_cycle <= 1'b1;
          wr_addr  <= addr_in;
        end
      end else if (!oe_f) begin
        in_cycle <= 1'b0;
      end else if (any_high) begin
        in_cycle <= 1'b0;
        wr_valid <= 1'b1;
        wr_data  <= data_in;
      end
    end
  end
endmodule

// File: rtl/wq_cmd_seq.sv
`timescale 1ns/1ps
// Unlock-sequence checker and read-mode tracking.
module wq_cmd_seq
  import flash_wq_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int NSECT = 8,
  parameter logic [AW-1:0] UNL_A0 = 'h555,
  parameter logic [DW-1:0] UNL_D0 = 'hAA,
  parameter logic [AW-1:0] UNL_A1 = 'h2AA,
  parameter logic [DW-1:0] UNL_D1 = 'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             op_done,
  input  logic             susp_en,
  input  logic [NSECT-1:0] susp_mask,
  input  logic [AW-1:0]    rd_addr,
  output logic             cmd_valid,
  output logic [DW-1:0]    cmd_data,
  output logic             read_array,
  output logic             rd_status
);
  localparam int SBITS = $clog2(NSECT);

  seq_state_t st;
  logic       hit0, hit1;
  logic [SBITS-1:0] sec;

  assign hit0 = (wr_addr == UNL_A0) && (wr_data == UNL_D0);
  assign hit1 = (wr_addr == UNL_A1) && (wr_data == UNL_D1);
  assign sec  = rd_addr[AW-1 -: SBITS];
  assign rd_status = !read_array || (susp_en && susp_mask[sec]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SEQ_UNL0;
      cmd_valid  <= 1'b0;
      cmd_data   <= '0;
      read_array <= 1'b1;
    end else begin
      cmd_valid <= 1'b0;
      if (wr_valid) begin
        case (st)
          SEQ_UNL0: begin
            if (hit0) st <= SEQ_UNL1;
            else      read_array <= 1'b1;
          end
          SEQ_UNL1: begin
            if (hit1) begin
              st <= SEQ_CMD;
            end else begin
              st         <= SEQ_UNL0;
              read_array <= 1'b1;
            end
          end
          SEQ_CMD: begin
            cmd_valid  <= 1'b1;
            cmd_data   <= wr_data;
            read_array <= 1'b0;
            st         <= SEQ_UNL0;
          end
          default: st <= SEQ_UNL0;
        endcase
      end else if (op_done) begin
        read_array <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_wr_qualifier.sv
`timescale 1ns/1ps
module flash_wr_qualifier
  import flash_wq_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int NSECT = 8,
  parameter int GLITCH_CYC = 3,
  parameter logic [AW-1:0] UNL_A0 = 'h555,
  parameter logic [DW-1:0] UNL_D0 = 'hAA,
  parameter logic [AW-1:0] UNL_A1 = 'h2AA,
  parameter logic [DW-1:0] UNL_D1 = 'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             op_done,
  input  logic             susp_en,
  input  logic [NSECT-1:0] susp_mask,
  input  logic [AW-1:0]    rd_addr,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             cmd_valid,
  output logic [DW-1:0]    cmd_data,
  output logic             read_array,
  output logic             rd_status,
  output logic             core_rst
);
  logic sup_q1, sup_q2, rst_int_n;
  logic [NPINS-1:0] pin_raw, pin_flt;

  // Supply-good synchronizer; its output resets everything downstream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q1    <= 1'b0;
      sup_q2    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      sup_q1    <= supply_ok;
      sup_q2    <= sup_q1;
      rst_int_n <= sup_q2;
    end
  end
  assign core_rst = !rst_int_n;

  assign pin_raw[PIN_CE] = ce_n;
  assign pin_raw[PIN_WE] = we_n;
  assign pin_raw[PIN_OE] = oe_n;

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    wq_pin_filter #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .pin_n (pin_raw[gi]),
      .flt_n (pin_flt[gi])
    );
  end

  wq_cycle_tracker #(.AW(AW), .DW(DW)) u_trk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ce_f     (pin_flt[PIN_CE]),
    .we_f     (pin_flt[PIN_WE]),
    .oe_f     (pin_flt[PIN_OE]),
    .addr_in  (bus_addr),
    .data_in  (bus_data),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  wq_cmd_seq #(
    .AW(AW), .DW(DW), .NSECT(NSECT),
    .UNL_A0(UNL_A0), .UNL_D0(UNL_D0), .UNL_A1(UNL_A1), .UNL_D1(UNL_D1)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .op_done    (op_done),
    .susp_en    (susp_en),
    .susp_mask  (susp_mask),
    .rd_addr    (rd_addr),
    .cmd_valid  (cmd_valid),
    .cmd_data   (cmd_data),
    .read_array (read_array),
    .rd_status  (rd_status)
  );
endmodule

// File: rtl/flash_wq_checker.sv
`timescale 1ns/1ps
module flash_wq_checker (
  input logic clk,
  input logic rst_n,
  input logic core_rst,
  input logic oe_f,
  input logic wr_valid,
  input logic cmd_valid,
  input logic read_array,
  input logic op_done
);
  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (!wr_valid && !cmd_valid && read_array));

  // R6
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R3
  a_r3_oe_high_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(oe_f));

  // R8
  a_r8_cmd_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_valid));

  // R8
  a_r8_cmd_enters_status: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !read_array);

  // R7
  a_r7_done_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !wr_valid) |=> read_array);
endmodule

bind flash_wr_qualifier flash_wq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst   (core_rst),
  .oe_f       (pin_flt[2]),
  .wr_valid   (wr_valid),
  .cmd_valid  (cmd_valid),
  .read_array (read_array),
  .op_done    (op_done)
);

// File: tb/flash_wr_qualifier_bench.sv
`timescale 1ns/1ps
module flash_wr_qualifier_bench;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int NS = 8;
  localparam int G  = 3;
  localparam int HOLD = G + 4;

  // {addr, data, expect_cmd, expect_read_array}
  localparam logic [20:0] VEC [0:9] = '{
    {11'h555, 8'hAA, 1'b0, 1'b1},
    {11'h2AA, 8'h55, 1'b0, 1'b1},
    {11'h123, 8'hA0, 1'b1, 1'b0},
    {11'h555, 8'hAA, 1'b0, 1'b0},
    {11'h2AA, 8'h54, 1'b0, 1'b1},
    {11'h555, 8'hAA, 1'b0, 1'b1},
    {11'h2AA, 8'h55, 1'b0, 1'b1},
    {11'h0FF, 8'h30, 1'b1, 1'b0},
    {11'h100, 8'hF0, 1'b0, 1'b1},
    {11'h555, 8'hAB, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic op_done = 1'b0;
  logic susp_en = 1'b0;
  logic [NS-1:0] susp_mask = '0;
  logic [AW-1:0] rd_addr = '0;
  logic wr_valid, cmd_valid, read_array, rd_status, core_rst;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, cmd_data;

  int n_chk = 0, n_err = 0;
  int n_wr = 0, n_cmd = 0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0, last_cmd = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_wr_qualifier #(.AW(AW), .DW(DW), .NSECT(NS), .GLITCH_CYC(G)) u_flash_wr_qualifier (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .op_done(op_done),
    .susp_en(susp_en), .susp_mask(susp_mask), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .read_array(read_array), .rd_status(rd_status), .core_rst(core_rst)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      n_wr   = n_wr + 1;
      last_a = wr_addr;
      last_d = wr_data;
    end
    if (cmd_valid) begin
      n_cmd    = n_cmd + 1;
      last_cmd = cmd_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ce_first: CE falls first so WE is the later fall.
  // we_rise_first: WE rises first, closing the cycle.
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit ce_first, input bit we_rise_first);
    @(negedge clk);
    bus_addr = a;
    bus_data = d;
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    cyc(HOLD);
    ce_n = 1'b0; we_n = 1'b0;
    cyc(HOLD);
    if (we_rise_first) we_n = 1'b1; else ce_n = 1'b1;
    cyc(HOLD);
    ce_n = 1'b1; we_n = 1'b1;
    cyc(HOLD);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    int w0, c0;
    cyc(3);
    rst_n = 1'b1;
    cyc(12);
    // Reset state: R7, R1
    chk("R7 read_array after reset", read_array, 1);
    chk("R1 core_rst low with supply", core_rst, 0);
    chk("R6 no strobe after reset", wr_valid, 0);
    chk("R8 no cmd after reset", cmd_valid, 0);

    // Vector walk: R5, R6, R8, R9
    for (int i = 0; i < 10; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic ec, er;
      {a, d, ec, er} = VEC[i];
      w0 = n_wr; c0 = n_cmd;
      bus_write(a, d, i[0], i[1]);
      chk("R6 one strobe per write", n_wr - w0, 1);
      chk("R5 captured address", last_a, a);
      chk("R6 captured data", last_d, d);
      chk("R8 cmd pulse count", n_cmd - c0, ec);
      if (ec) chk("R8 cmd byte", last_cmd, d);
      chk("R9 read_array after write", read_array, er);
    end

    // R5: address at the later fall; changes afterwards are ignored.
    @(negedge clk);
    bus_addr = 11'h011; bus_data = 8'h5A; ce_n = 1'b0;
    cyc(HOLD);
    bus_addr = 11'h022; we_n = 1'b0;
    cyc(HOLD);
    bus_addr = 11'h033;
    // R6: data at the earlier rise, exact latency.
    we_n = 1'b1;
    cyc(G + 2);
    chk("R6 strobe not before G+3 edges", wr_valid, 0);
    cyc(1);
    chk("R6 strobe at G+3 edges", wr_valid, 1);
    chk("R5 later-fall address", wr_addr, 11'h022);
    chk("R6 earlier-rise data", wr_data, 8'h5A);
    cyc(1);
    chk("R6 strobe one cycle wide", wr_valid, 0);
    bus_data = 8'hC3;
    cyc(HOLD);
    ce_n = 1'b1;
    cyc(HOLD);
    chk("R6 later rise adds no strobe", last_d, 8'h5A);

    // R2: WE pulse shorter than G ignored.
    w0 = n_wr;
    ce_n = 1'b0; cyc(HOLD);
    we_n = 1'b0; cyc(G - 1);
    we_n = 1'b1; cyc(HOLD);
    ce_n = 1'b1; cyc(HOLD);
    chk("R2 short WE pulse ignored", n_wr - w0, 0);
    // R2: WE pulse of exactly G accepted.
    ce_n = 1'b0; cyc(HOLD);
    we_n = 1'b0; cyc(G);
    we_n = 1'b1; cyc(HOLD);
    ce_n = 1'b1; cyc(HOLD);
    chk("R2 G-wide WE pulse accepted", n_wr - w0, 1);
    // R2: short OE glitch during a write does not abort it.
    w0 = n_wr;
    ce_n = 1'b0; we_n = 1'b0; cyc(HOLD);
    oe_n = 1'b0; cyc(G - 1);
    oe_n = 1'b1; cyc(HOLD);
    we_n = 1'b1; ce_n = 1'b1; cyc(HOLD);
    chk("R2 short OE glitch ignored", n_wr - w0, 1);

    // R3: OE low inhibits writes.
    w0 = n_wr;
    oe_n = 1'b0; cyc(2);
    ce_n = 1'b0; we_n = 1'b0; cyc(HOLD);
    we_n = 1'b1; ce_n = 1'b1; cyc(HOLD);
    oe_n = 1'b1; cyc(HOLD);
    chk("R3 no write with OE low", n_wr - w0, 0);

    // R7: op_done returns to read-array.
    bus_write(11'h555, 8'hAA, 1, 1);
    bus_write(11'h2AA, 8'h55, 0, 0);
    bus_write(11'h040, 8'h80, 1, 0);
    chk("R8 status mode after command", read_array, 0);
    // R10: status mode forces status reads.
    rd_addr = 11'h510;
    chk("R10 status in status mode", rd_status, 1);
    op_done = 1'b1; cyc(1);
    op_done = 1'b0;
    chk("R7 read_array after op_done", read_array, 1);

    // R10: erase-suspend sector match.
    susp_en = 1'b1; susp_mask = 8'h04;
    rd_addr = 11'h210; cyc(1);
    chk("R10 suspended sector gives status", rd_status, 1);
    rd_addr = 11'h510; cyc(1);
    chk("R10 other sector gives array", rd_status, 0);
    susp_en = 1'b0; rd_addr = 11'h210; cyc(1);
    chk("R10 no suspend gives array", rd_status, 0);

    // R1: supply loss resets mode and blocks writes.
    bus_write(11'h555, 8'hAA, 0, 1);
    bus_write(11'h2AA, 8'h55, 1, 0);
    bus_write(11'h077, 8'h10, 0, 0);
    chk("R8 status before supply loss", read_array, 0);
    supply_ok = 1'b0; cyc(4);
    chk("R1 core_rst on supply loss", core_rst, 1);
    chk("R1 read_array on supply loss", read_array, 1);
    w0 = n_wr;
    bus_write(11'h555, 8'hAA, 1, 1);
    chk("R1 writes ignored at low supply", n_wr - w0, 0);
    supply_ok = 1'b1; cyc(HOLD + 4);
    chk("R1 core_rst released", core_rst, 0);
    bus_write(11'h321, 8'h12, 1, 1);
    chk("R1 writes resume", n_wr - w0, 1);

    // R4: power-up with CE and WE low.
    w0 = n_wr;
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(HOLD + 6);
    we_n = 1'b1; cyc(HOLD);
    ce_n = 1'b1; cyc(HOLD);
    chk("R4 no strobe on first WE rise", n_wr - w0, 0);
    bus_write(11'h0AB, 8'hCD, 0, 1);
    chk("R4 later write accepted", n_wr - w0, 1);
    chk("R4 later write data", last_d, 8'hCD);

    if (!finished) begin
      finished = 1;
      report();
    end
  end
endmodule